// File: doc/BRIEF.md
# Serial Peripheral Front-End with Hold Pause

This block is the serial front end of a small memory-style SPI slave. It works in the system clock domain. Chip select, serial clock, serial data in and the active-low hold input are each brought in through a two-flop synchronizer, and the block detects clock edges from the synchronized copies. It assembles incoming bits into bytes, most significant bit first, and reports each complete byte with a one-cycle strobe. It drives serial data out on a separate data and output-enable pair, so a pad can tri-state the line. The system clock must run at least four times faster than the serial clock.

A hold pause freezes the shift sequence in place and floats the output. The block enters and leaves a pause only while the serial clock is low. Raising chip select during a pause aborts the transfer. The block also keeps a small status byte. Its write enable and busy bits are cleared by the power-on reset. Its three protection bits live in flops that reset never touches, so they act as non-volatile bits. After power-on the block starts deselected. It accepts no command until it has seen a falling edge on chip select.

Top module: `spi_hold_frontend`

## Requirements
- R1: Data in is sampled on rising serial-clock edges in SPI mode 0, most significant bit first. After the eighth rising edge of a byte, `rx_valid_o` pulses for one cycle with the byte on `rx_byte_o`, and `bit_cnt_o` returns to 0.
- R2: After opcode 0x05, the status byte is shifted out on `miso_o`, most significant bit first. Each new bit appears after a falling edge of the serial clock. The byte repeats for as long as chip select stays low. `miso_oe_o` is 1 only during this response.
- R3: While the pause is active, `hold_o` is 1 and `miso_oe_o` is 0. Serial-clock and data-in activity is ignored, and `bit_cnt_o` stays unchanged.
- R4: The pause starts when `holdn_i` is low while the serial clock is low, and it ends when `holdn_i` is high while the serial clock is low. A change of `holdn_i` made while the clock is high takes effect after the next falling edge. No pause starts while the block is deselected.
- R5: When the pause ends, shifting resumes at the same bit position. A byte split by a pause is received and transmitted intact.
- R6: Raising chip select during a pause clears the pause and sets `bit_cnt_o` to 0.
- R7: The status byte holds busy (the registered `busy_i`) at bit 0, the write enable latch at bit 1, protection bit A at bit 2, protection bit B at bit 3 and the protect-lock bit at bit 7. Bits 6 to 4 read as 0.
- R8: Opcode 0x06 sets the write enable latch, and opcode 0x04 clears it. Opcode 0x01 sent with the latch set copies bits 7, 3 and 2 of the next byte into the protection bits and clears the latch. Opcode 0x01 sent with the latch clear changes nothing.
- R9: Power-on reset clears the write enable latch and the busy bit, and leaves the three protection bits unchanged.
- R10: After reset, no byte is received until chip select has gone from high to low. Chip select held low through reset starts no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| csn_i | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock |
| mosi_i | input | 1 | Serial data in |
| holdn_i | input | 1 | Hold request, active low |
| busy_i | input | 1 | Write-cycle busy flag from the core |
| miso_o | output | 1 | Serial data out |
| miso_oe_o | output | 1 | Output enable for serial data out |
| rx_valid_o | output | 1 | One-cycle strobe for a received byte |
| rx_byte_o | output | 8 | Last received byte |
| bit_cnt_o | output | 3 | Bit position within the current byte |
| hold_o | output | 1 | Pause active |

## Verification
The hardest case to reach is a pause that lands in the middle of a status response. The bench stops after four bits of the second byte, with the clock low, so the pause freezes the receive and transmit positions together. It then toggles the clock and data lines while the pause is active, and checks that both bytes reassemble correctly after release. A second scenario lowers the hold input while the clock is high and confirms that entry waits for the falling edge. It then deselects the block while the pause is still active. A third scenario keeps chip select low from before reset, so that the bench can show that the first command is ignored.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = $clog2(BYTE_W);

  localparam logic [BYTE_W-1:0] OP_WREN = 8'h06;
  localparam logic [BYTE_W-1:0] OP_WRDI = 8'h04;
  localparam logic [BYTE_W-1:0] OP_RDSR = 8'h05;
  localparam logic [BYTE_W-1:0] OP_WRSR = 8'h01;

  localparam int unsigned ST_WIP  = 0;
  localparam int unsigned ST_WEL  = 1;
  localparam int unsigned ST_PB_A = 2;
  localparam int unsigned ST_PB_B = 3;
  localparam int unsigned ST_LOCK = 7;

  typedef enum logic [1:0] {C_OPCODE, C_RDSR, C_WRSR, C_SKIP} cmd_state_e;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s0_q, s1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s0_q <= RST_VAL;
      s1_q <= RST_VAL;
    end else begin
      s0_q <= d_i;
      s1_q <= s0_q;
    end
  end

  assign q_o = s1_q;
endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic csn_s_i,
  input  logic sck_s_i,
  input  logic holdn_s_i,
  output logic sel_o,
  output logic hold_o,
  output logic rise_o,
  output logic fall_o
);
  logic csn_d_q, sck_d_q, sel_q, hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csn_d_q <= 1'b0; // low at reset: a held-low select never looks like a fall
      sck_d_q <= 1'b0;
      sel_q   <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      csn_d_q <= csn_s_i;
      sck_d_q <= sck_s_i;
      if (csn_s_i)                 sel_q <= 1'b0;
      else if (csn_d_q)            sel_q <= 1'b1;
      if (!sel_q || csn_s_i)       hold_q <= 1'b0;
      else if (!sck_s_i)           hold_q <= ~holdn_s_i;
    end
  end

  logic active;
  assign active = sel_q & ~hold_q & ~csn_s_i;
  assign rise_o = active &  sck_s_i & ~sck_d_q;
  assign fall_o = active & ~sck_s_i &  sck_d_q;
  assign sel_o  = sel_q;
  assign hold_o = hold_q;

  AST_NO_ENTRY_SCK_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_q && sck_s_i) |=> !hold_q); // R4
  AST_NO_EXIT_SCK_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_q && sck_s_i && !csn_s_i) |=> hold_q); // R4
  AST_NO_HOLD_DESEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csn_s_i |=> !hold_q); // R6
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter
  import spi_hold_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              hold_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mosi_i,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] load_byte_i,
  output logic              rx_valid_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              miso_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-2:0] rx_sr_q;
  logic [BYTE_W-1:0] rx_byte_q, tx_sr_q;
  logic              rx_valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      rx_sr_q    <= '0;
      rx_byte_q  <= '0;
      rx_valid_q <= 1'b0;
      tx_sr_q    <= '0;
    end else begin
      rx_valid_q <= 1'b0;
      if (!sel_i) begin
        cnt_q <= '0;
      end else if (rise_i) begin
        if (cnt_q == LAST) begin
          cnt_q      <= '0;
          rx_byte_q  <= {rx_sr_q, mosi_i};
          rx_valid_q <= 1'b1;
        end else begin
          cnt_q   <= cnt_q + 1'b1;
          rx_sr_q <= {rx_sr_q[BYTE_W-3:0], mosi_i};
        end
      end
      // no shift on the fall that closes a byte: the next byte's MSB must stay
      if (load_i)                       tx_sr_q <= load_byte_i;
      else if (fall_i && cnt_q != '0)   tx_sr_q <= {tx_sr_q[BYTE_W-2:0], 1'b0};
    end
  end

  assign rx_valid_o = rx_valid_q;
  assign rx_byte_o  = rx_byte_q;
  assign cnt_o      = cnt_q;
  assign miso_o     = tx_sr_q[BYTE_W-1];

  AST_CNT_FROZEN_IN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && sel_i) |=> $stable(cnt_q)); // R3
  AST_DESEL_CNT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> (cnt_q == '0)); // R6
endmodule

// File: rtl/spi_hold_frontend.sv
module spi_hold_frontend
  import spi_hold_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csn_i,
  input  logic              sck_i,
  input  logic              mosi_i,
  input  logic              holdn_i,
  input  logic              busy_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  output logic              rx_valid_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic [CNT_W-1:0]  bit_cnt_o,
  output logic              hold_o
);
  logic csn_s, sck_s, mosi_s, holdn_s;
  logic sel, hold, rise, fall, load;
  logic [BYTE_W-1:0] status_w;
  cmd_state_e cmd_q;
  logic wel_q, wip_q;
  logic [2:0] prot_q; // {lock, pb_b, pb_a}; no reset, survives power-on reset

  spi_sync #(.W(4), .RST_VAL(4'b1000)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({holdn_i, mosi_i, sck_i, csn_i}),
    .q_o   ({holdn_s, mosi_s, sck_s, csn_s})
  );

  spi_hold_ctrl u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .csn_s_i  (csn_s),
    .sck_s_i  (sck_s),
    .holdn_s_i(holdn_s),
    .sel_o    (sel),
    .hold_o   (hold),
    .rise_o   (rise),
    .fall_o   (fall)
  );

  spi_shifter u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (sel),
    .hold_i     (hold),
    .rise_i     (rise),
    .fall_i     (fall),
    .mosi_i     (mosi_s),
    .load_i     (load),
    .load_byte_i(status_w),
    .rx_valid_o (rx_valid_o),
    .rx_byte_o  (rx_byte_o),
    .cnt_o      (bit_cnt_o),
    .miso_o     (miso_o)
  );

  always_comb begin
    status_w          = '0;
    status_w[ST_WIP]  = wip_q;
    status_w[ST_WEL]  = wel_q;
    status_w[ST_PB_A] = prot_q[0];
    status_w[ST_PB_B] = prot_q[1];
    status_w[ST_LOCK] = prot_q[2];
  end

  logic byte_in;
  assign byte_in = rx_valid_o & sel;
  assign load    = byte_in & ((cmd_q == C_OPCODE && rx_byte_o == OP_RDSR) || cmd_q == C_RDSR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= C_OPCODE;
      wel_q <= 1'b0;
      wip_q <= 1'b0;
    end else begin
      wip_q <= busy_i;
      if (!sel) begin
        cmd_q <= C_OPCODE;
      end else if (byte_in) begin
        unique case (cmd_q)
          C_OPCODE: begin
            cmd_q <= C_SKIP;
            if (rx_byte_o == OP_WREN) wel_q <= 1'b1;
            if (rx_byte_o == OP_WRDI) wel_q <= 1'b0;
            if (rx_byte_o == OP_RDSR) cmd_q <= C_RDSR;
            if (rx_byte_o == OP_WRSR && wel_q) cmd_q <= C_WRSR;
          end
          C_WRSR: begin
            wel_q <= 1'b0;
            cmd_q <= C_SKIP;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (byte_in && cmd_q == C_WRSR)
      prot_q <= {rx_byte_o[ST_LOCK], rx_byte_o[ST_PB_B], rx_byte_o[ST_PB_A]};
  end

  assign miso_oe_o = sel & ~hold & (cmd_q == C_RDSR);
  assign hold_o    = hold;

  AST_RX_ONLY_SELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_valid_o) |-> $past(sel)); // R10
  AST_WEL_DROPS_AFTER_WRSR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_in && cmd_q == C_WRSR) |=> !wel_q); // R8
endmodule

// File: tb/spi_hold_frontend_tb_top.sv
module spi_hold_frontend_tb_top;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_ni, csn, sck, mosi, holdn, busy;
  logic miso, miso_oe, rx_valid, hold;
  logic [7:0] rx_byte;
  logic [2:0] bit_cnt;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  spi_hold_frontend dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .csn_i(csn), .sck_i(sck), .mosi_i(mosi),
    .holdn_i(holdn), .busy_i(busy), .miso_o(miso), .miso_oe_o(miso_oe),
    .rx_valid_o(rx_valid), .rx_byte_o(rx_byte), .bit_cnt_o(bit_cnt), .hold_o(hold)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each received byte
  always @(negedge clk) begin
    if (rst_ni && rx_valid) begin
      if (exp_q.size() == 0) begin
        chk("R10 unexpected byte", {24'h0, rx_byte}, 32'hFFFF_FFFF);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(t, {24'h0, rx_byte}, {24'h0, e});
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // pause after 'hold_at' bits (8 = none); scrambles clock and data during the pause
  task automatic xfer(input logic [7:0] tx, input bit expect_rx, input int hold_at,
                      output logic [7:0] rx);
    if (expect_rx) begin
      exp_q.push_back(tx);
      tag_q.push_back("R1/R5 rx byte");
    end
    for (int i = 7; i >= 0; i--) begin
      if (7 - i == hold_at) begin
        logic [2:0] cnt_before;
        chk("R2 oe before pause", {31'h0, miso_oe}, 32'h1);
        holdn = 1'b0;
        wait_clk(HALF);
        cnt_before = bit_cnt;
        chk("R3 hold_o in pause", {31'h0, hold}, 32'h1);
        chk("R3 oe off in pause", {31'h0, miso_oe}, 32'h0);
        for (int k = 0; k < 3; k++) begin
          mosi = ~mosi; sck = 1'b1; wait_clk(HALF);
          sck = 1'b0; wait_clk(HALF);
        end
        chk("R3 cnt frozen in pause", {29'h0, bit_cnt}, {29'h0, cnt_before});
        holdn = 1'b1;
        wait_clk(HALF);
        chk("R4 pause ends, clk low", {31'h0, hold}, 32'h0);
      end
      mosi = tx[i];
      wait_clk(HALF);
      sck = 1'b1;
      rx[i] = miso;
      wait_clk(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic select();
    csn = 1'b0; wait_clk(HALF);
  endtask

  task automatic deselect();
    wait_clk(HALF); csn = 1'b1; wait_clk(2 * HALF);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] r;
    select(); xfer(op, 1'b1, 8, r); deselect();
  endtask

  task automatic read_status(output logic [7:0] st);
    logic [7:0] r;
    select();
    xfer(8'h05, 1'b1, 8, r);
    xfer(8'h00, 1'b1, 8, st);
    deselect();
  endtask

  initial begin
    wait_clk(100000);
    chk("watchdog", 32'h0, 32'h1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] st, r, r2;
    rst_ni = 1'b0; csn = 1'b0; sck = 1'b0; mosi = 1'b0; holdn = 1'b1; busy = 1'b0;
    wait_clk(5);
    rst_ni = 1'b1;
    wait_clk(4);
    chk("reset oe", {31'h0, miso_oe}, 32'h0);
    chk("reset hold", {31'h0, hold}, 32'h0);
    chk("reset cnt", {29'h0, bit_cnt}, 32'h0);

    // chip select low through reset: WREN must be ignored
    xfer(8'h06, 1'b0, 8, r);
    wait_clk(2);
    chk("R10 cnt idle without fall", {29'h0, bit_cnt}, 32'h0);
    csn = 1'b1; wait_clk(2 * HALF);
    read_status(st);
    chk("R10 WEL still clear", {24'h0, st & 8'h73}, 32'h0);

    cmd1(8'h06);
    read_status(st);
    chk("R8 WREN sets WEL", {24'h0, st & 8'h73}, 32'h02);

    select(); xfer(8'h01, 1'b1, 8, r); xfer(8'hFF, 1'b1, 8, r); deselect();
    read_status(st);
    chk("R7/R8 WRSR writes prot bits", {24'h0, st}, 32'h8C);

    select(); xfer(8'h01, 1'b1, 8, r); xfer(8'h00, 1'b1, 8, r); deselect();
    read_status(st);
    chk("R8 WRSR without WEL ignored", {24'h0, st}, 32'h8C);

    cmd1(8'h06); cmd1(8'h04);
    read_status(st);
    chk("R8 WRDI clears WEL", {24'h0, st}, 32'h8C);

    busy = 1'b1; wait_clk(4);
    read_status(st);
    chk("R7 busy at bit 0", {24'h0, st}, 32'h8D);
    busy = 1'b0; wait_clk(4);

    // status response repeats and survives a mid-byte pause
    select();
    xfer(8'h05, 1'b1, 8, r);
    xfer(8'h00, 1'b1, 8, r);
    chk("R2 first status byte", {24'h0, r}, 32'h8C);
    xfer(8'hA5, 1'b1, 4, r2);
    chk("R5 split status byte", {24'h0, r2}, 32'h8C);
    deselect();
    chk("R2 oe off after deselect", {31'h0, miso_oe}, 32'h0);

    // hold lowered with clock high waits for the falling edge
    select();
    mosi = 1'b1; wait_clk(HALF);
    sck = 1'b1; wait_clk(HALF);
    holdn = 1'b0; wait_clk(HALF);
    chk("R4 no entry while clk high", {31'h0, hold}, 32'h0);
    sck = 1'b0; wait_clk(HALF);
    chk("R4 entry after fall", {31'h0, hold}, 32'h1);
    sck = 1'b1; wait_clk(HALF); sck = 1'b0; wait_clk(HALF);
    chk("R3 cnt held at 1", {29'h0, bit_cnt}, 32'h1);
    csn = 1'b1; wait_clk(HALF);
    chk("R6 deselect clears hold", {31'h0, hold}, 32'h0);
    chk("R6 deselect clears cnt", {29'h0, bit_cnt}, 32'h0);
    wait_clk(HALF);
    chk("R4 no pause while deselected", {31'h0, hold}, 32'h0);
    holdn = 1'b1; wait_clk(2 * HALF);

    // power-on reset keeps protection bits
    cmd1(8'h06);
    busy = 1'b1; wait_clk(4);
    busy = 1'b0; rst_ni = 1'b0; wait_clk(3); rst_ni = 1'b1; wait_clk(4);
    chk("R9 cnt after reset", {29'h0, bit_cnt}, 32'h0);
    read_status(st);
    chk("R9 prot kept, WEL/WIP clear", {24'h0, st}, 32'h8C);

    wait_clk(4);
    chk("R1 all bytes seen", exp_q.size(), 32'h0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule